// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block moves words in one direction from a write clock domain to a read clock domain. The two clocks may be unrelated or the same net. Each side has its own chip select (active low) and enable (active high). A transfer happens only on a rising edge of that side's clock where both are asserted. Four registered status outputs report the state of the buffer. A ready flag on each side says whether a transfer can proceed. A threshold flag on each side is pulled LOW when the buffer is nearly empty (read side) or nearly full (write side).

Two read timing modes are available, chosen by a pin that is sampled on the first clock edge after reset is released. In strobed mode the read-side ready flag means "memory is not empty", and a word appears on the read bus only after a read transfer. In fall-through mode the first stored word is moved into an output stage without any request. The read-side ready flag then means "a valid word is on the bus now", and each read transfer retires that word. The two threshold offsets are sampled on that same edge and then hold until the next reset.

Top module: `dual_clk_fifo`

## Requirements
- R1: A write or read is performed only on a rising edge of its own clock where its chip select is LOW and its enable is HIGH. Any other combination leaves the contents, the read bus and the flags unchanged.
- R2: `wr_nfull` is HIGH exactly when at least one storage location is free, in both modes. A write attempted while it is LOW is discarded.
- R3: In strobed mode, `rd_nempty` is HIGH exactly when at least one word is stored. After a read transfer, the oldest word is on `rd_data` from the following clock edge. A read attempted while `rd_nempty` is LOW leaves `rd_data` unchanged.
- R4: In fall-through mode, the oldest word is placed on `rd_data` and `rd_nempty` goes HIGH without any read request. A read transfer retires it, and the next word, if one exists, follows on the next edge.
- R5: `rd_ae_n` is LOW exactly when the stored word count is less than or equal to the captured read-side offset. In fall-through mode, the word held on the bus counts as stored.
- R6: `wr_af_n` is LOW exactly when the number of free storage locations is less than or equal to the captured write-side offset.
- R7: `tmode` (1 = strobed, 0 = fall-through), `ae_offset` and `af_offset` are sampled on the first clock edge after reset is released in each domain. Later changes to these pins have no effect until the next reset.
- R8: Words leave in the order they were accepted, with unchanged values, even when the two clocks have unrelated periods.
- R9: While `mrst_n` is LOW and after it is released, the buffer is empty: `rd_nempty` LOW, `rd_ae_n` LOW, `wr_nfull` HIGH, and `wr_af_n` HIGH when the write-side offset is below the depth.
- R10: The write and read pointers that cross between domains change by at most one bit per clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mrst_n | input | 1 | Master reset, active low, asynchronous assertion |
| tmode | input | 1 | Timing mode select: 1 strobed, 0 fall-through |
| wr_clk | input | 1 | Write-side clock |
| wr_cs_n | input | 1 | Write chip select, active low |
| wr_en | input | 1 | Write enable, active high |
| wr_data | input | DW | Word to store |
| af_offset | input | $clog2(DEPTH)+1 | Free-space threshold for `wr_af_n` |
| wr_nfull | output | 1 | HIGH while a location is free |
| wr_af_n | output | 1 | LOW while free locations are at or below the threshold |
| rd_clk | input | 1 | Read-side clock |
| rd_cs_n | input | 1 | Read chip select, active low |
| rd_en | input | 1 | Read enable, active high |
| ae_offset | input | $clog2(DEPTH)+1 | Stored-word threshold for `rd_ae_n` |
| rd_data | output | DW | Word read out |
| rd_nempty | output | 1 | Strobed mode: data stored. Fall-through mode: valid word on `rd_data` |
| rd_ae_n | output | 1 | LOW while stored words are at or below the threshold |

## Verification
A corrupted pointer, or a pointer that stops advancing, appears at the ports as a word out of sequence, a repeated word, or a lost word on `rd_data`. It also shows as a threshold flag that is wrong at a settled fill level. Both become visible within a few cycles of the next read, or once both domains have settled. A wrongly captured mode shows on the first write after reset: in fall-through mode a word must be on the bus with no strobe. A wrongly captured offset makes `rd_ae_n` or `wr_af_n` disagree with the fill level at the first check after the crossing settles. A flag that is stale by one update lets a write into a full buffer, or a read from an empty one, get through. That shows up as an extra word, or as a word that never arrives, when the buffer is drained.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    typedef enum logic {
        TM_FWFT = 1'b0,
        TM_STD  = 1'b1
    } tmode_e;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n
);
    logic [1:0] stage_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stage_q <= 2'b00;
        else         stage_q <= {stage_q[0], 1'b1};
    end

    assign rst_n = stage_q[1];
endmodule

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] gray_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] safe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            safe_q <= '0;
        end else begin
            meta_q <= gray_i;
            safe_q <= meta_q;
        end
    end

    assign gray_o = safe_q;
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
    import dcf_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n_i,
    input  logic          en_i,
    input  logic [PW-1:0] af_ofs_i,
    input  logic [PW-1:0] rgray_sync_i,
    output logic          push_o,
    output logic [AW-1:0] waddr_o,
    output logic [PW-1:0] wgray_o,
    output logic          nfull_o,
    output logic          af_n_o
);
    typedef struct packed {
        logic [PW-1:0] wbin;
        logic [PW-1:0] wgray;
        logic [PW-1:0] af_ofs;
        logic          nfull;
        logic          af_n;
        logic          live;
    } wst_t;

    localparam wst_t WST_RESET = '{
        wbin: '0, wgray: '0, af_ofs: '0, nfull: 1'b1, af_n: 1'b1, live: 1'b0
    };

    wst_t          q, d;
    logic [PW-1:0] rbin;
    logic [PW-1:0] ofs;
    logic [PW-1:0] lvl_now;
    logic [PW-1:0] lvl_nxt;
    logic [PW-1:0] free_nxt;
    logic          req;

    always_comb begin
        d        = q;
        rbin     = PW'(gray_to_bin(32'(rgray_sync_i)));
        req      = !cs_n_i && en_i;
        push_o   = req && q.nfull && q.live;
        ofs      = q.live ? q.af_ofs : af_ofs_i;
        d.live   = 1'b1;
        d.af_ofs = ofs;
        d.wbin   = q.wbin + PW'(push_o);
        d.wgray  = PW'(bin_to_gray(32'(d.wbin)));
        lvl_now  = q.wbin - rbin;
        lvl_nxt  = d.wbin - rbin;
        free_nxt = PW'(DEPTH) - lvl_nxt;
        d.nfull  = (free_nxt != '0);
        d.af_n   = !(free_nxt <= ofs);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= WST_RESET;
        else        q <= d;
    end

    assign waddr_o = q.wbin[AW-1:0];
    assign wgray_o = q.wgray;
    assign nfull_o = q.nfull;
    assign af_n_o  = q.af_n;

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_now <= PW'(DEPTH));

    // R2
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !q.nfull) |=> $stable(q.wbin));

    // R1
    idle_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i || !en_i) |=> $stable(q.wbin));

    // R10
    wgray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.live |-> ($countones(q.wgray ^ $past(q.wgray)) <= 1));
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
    import dcf_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int DW    = 36,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n_i,
    input  logic          en_i,
    input  logic          mode_i,
    input  logic [PW-1:0] ae_ofs_i,
    input  logic [PW-1:0] wgray_sync_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic [AW-1:0] raddr_o,
    output logic [PW-1:0] rgray_o,
    output logic [DW-1:0] data_o,
    output logic          nempty_o,
    output logic          ae_n_o
);
    typedef struct packed {
        logic [PW-1:0] rbin;
        logic [PW-1:0] rgray;
        logic [DW-1:0] data;
        logic [PW-1:0] ae_ofs;
        tmode_e        mode;
        logic          ovalid;
        logic          nempty;
        logic          ae_n;
        logic          live;
    } rst_t;

    localparam rst_t RST_RESET = '{
        rbin: '0, rgray: '0, data: '0, ae_ofs: '0, mode: TM_STD,
        ovalid: 1'b0, nempty: 1'b0, ae_n: 1'b0, live: 1'b0
    };

    rst_t          q, d;
    tmode_e        mode;
    logic [PW-1:0] ofs;
    logic [PW-1:0] wbin;
    logic [PW-1:0] cnt_nxt;
    logic          mem_has;
    logic          req;
    logic          take;
    logic          pop;

    always_comb begin
        d        = q;
        mode     = q.live ? q.mode : tmode_e'(mode_i);
        ofs      = q.live ? q.ae_ofs : ae_ofs_i;
        d.live   = 1'b1;
        d.mode   = mode;
        d.ae_ofs = ofs;
        wbin     = PW'(gray_to_bin(32'(wgray_sync_i)));
        mem_has  = (wbin != q.rbin);
        req      = !cs_n_i && en_i && q.live;
        take     = 1'b0;
        pop      = 1'b0;
        if (mode == TM_STD) begin
            pop      = req && q.nempty;
            d.ovalid = 1'b0;
        end else begin
            take     = req && q.ovalid;
            pop      = q.live && mem_has && (!q.ovalid || take);
            d.ovalid = pop | (q.ovalid & ~take);
        end
        if (pop) begin
            d.data = mem_rdata_i;
            d.rbin = q.rbin + 1'b1;
        end
        d.rgray  = PW'(bin_to_gray(32'(d.rbin)));
        cnt_nxt  = wbin - d.rbin + PW'((mode == TM_FWFT) && d.ovalid);
        d.nempty = (mode == TM_STD) ? (wbin != d.rbin) : d.ovalid;
        d.ae_n   = !(cnt_nxt <= ofs);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_RESET;
        else        q <= d;
    end

    assign raddr_o  = q.rbin[AW-1:0];
    assign rgray_o  = q.rgray;
    assign data_o   = q.data;
    assign nempty_o = q.nempty;
    assign ae_n_o   = q.ae_n;

    // R3
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.live && q.mode == TM_STD && !q.nempty) |=> $stable(q.data));

    // R4
    fwft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.live && q.mode == TM_FWFT && q.ovalid && (cs_n_i || !en_i))
        |=> ($stable(q.data) && q.ovalid));

    // R1
    idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.live && q.mode == TM_STD && (cs_n_i || !en_i)) |=> $stable(q.rbin));

    // R10
    rgray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.live |-> ($countones(q.rgray ^ $past(q.rgray)) <= 1));
endmodule

// File: rtl/dual_clk_fifo.sv
module dual_clk_fifo
    import dcf_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int DW    = 36,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          mrst_n,
    input  logic          tmode,
    input  logic          wr_clk,
    input  logic          wr_cs_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [PW-1:0] af_offset,
    output logic          wr_nfull,
    output logic          wr_af_n,
    input  logic          rd_clk,
    input  logic          rd_cs_n,
    input  logic          rd_en,
    input  logic [PW-1:0] ae_offset,
    output logic [DW-1:0] rd_data,
    output logic          rd_nempty,
    output logic          rd_ae_n
);
    logic          wr_rst_n, rd_rst_n;
    logic          push;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wgray, rgray, wgray_rs, rgray_ws;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] mem_q [DEPTH];

    dcf_rst_sync u_wr_rst (.clk(wr_clk), .arst_n(mrst_n), .rst_n(wr_rst_n));
    dcf_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(mrst_n), .rst_n(rd_rst_n));

    dcf_gray_sync #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst_n(rd_rst_n), .gray_i(wgray), .gray_o(wgray_rs)
    );
    dcf_gray_sync #(.W(PW)) u_r2w (
        .clk(wr_clk), .rst_n(wr_rst_n), .gray_i(rgray), .gray_o(rgray_ws)
    );

    dcf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .cs_n_i(wr_cs_n), .en_i(wr_en),
        .af_ofs_i(af_offset), .rgray_sync_i(rgray_ws), .push_o(push),
        .waddr_o(waddr), .wgray_o(wgray), .nfull_o(wr_nfull), .af_n_o(wr_af_n)
    );

    dcf_rd_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .cs_n_i(rd_cs_n), .en_i(rd_en),
        .mode_i(tmode), .ae_ofs_i(ae_offset), .wgray_sync_i(wgray_rs),
        .mem_rdata_i(mem_rdata), .raddr_o(raddr), .rgray_o(rgray),
        .data_o(rd_data), .nempty_o(rd_nempty), .ae_n_o(rd_ae_n)
    );

    always_ff @(posedge wr_clk) begin
        if (push) mem_q[waddr] <= wr_data;
    end

    assign mem_rdata = mem_q[raddr];
endmodule

// File: tb/sim_dual_clk_fifo.sv
module sim_dual_clk_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int RD_PERIOD  = 14;
    localparam int DEPTH      = 16;
    localparam int DW         = 36;
    localparam int PW         = 5;
    localparam int AE_OFS     = 3;
    localparam int AF_OFS     = 4;

    typedef struct packed {
        logic [4:0] nw;
        logic [4:0] nr;
        logic       ne;
        logic       ae;
        logic       af;
        logic       nf;
    } vec_t;

    // cumulative level: 3,4,11,12,16,16,11,3,0,0
    localparam vec_t VEC [10] = '{
        '{5'd3, 5'd0, 1'b1, 1'b0, 1'b1, 1'b1},
        '{5'd1, 5'd0, 1'b1, 1'b1, 1'b1, 1'b1},
        '{5'd7, 5'd0, 1'b1, 1'b1, 1'b1, 1'b1},
        '{5'd1, 5'd0, 1'b1, 1'b1, 1'b0, 1'b1},
        '{5'd4, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{5'd2, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{5'd0, 5'd5, 1'b1, 1'b1, 1'b1, 1'b1},
        '{5'd0, 5'd8, 1'b1, 1'b0, 1'b1, 1'b1},
        '{5'd0, 5'd3, 1'b0, 1'b0, 1'b1, 1'b1},
        '{5'd0, 5'd2, 1'b0, 1'b0, 1'b1, 1'b1}
    };

    logic          mrst_n, tmode;
    logic          wr_clk, wr_cs_n, wr_en, wr_nfull, wr_af_n;
    logic [DW-1:0] wr_data;
    logic [PW-1:0] af_offset, ae_offset;
    logic          rd_clk, rd_cs_n, rd_en, rd_nempty, rd_ae_n;
    logic [DW-1:0] rd_data;

    int n_chk = 0, n_fail = 0;
    int wseq = 0, rseq = 0, lvl = 0;
    bit fwft = 0, done = 0;

    dual_clk_fifo #(.DEPTH(DEPTH), .DW(DW)) u0 (
        .mrst_n(mrst_n), .tmode(tmode), .wr_clk(wr_clk), .wr_cs_n(wr_cs_n),
        .wr_en(wr_en), .wr_data(wr_data), .af_offset(af_offset),
        .wr_nfull(wr_nfull), .wr_af_n(wr_af_n), .rd_clk(rd_clk),
        .rd_cs_n(rd_cs_n), .rd_en(rd_en), .ae_offset(ae_offset),
        .rd_data(rd_data), .rd_nempty(rd_nempty), .rd_ae_n(rd_ae_n)
    );

    initial wr_clk = 1'b0;
    always #(CLK_PERIOD / 2) wr_clk = ~wr_clk;
    initial rd_clk = 1'b0;
    always #(RD_PERIOD / 2) rd_clk = ~rd_clk;

    function automatic logic [DW-1:0] pat(input int s);
        return {18'(s), ~18'(s)};
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(posedge rd_clk);
        repeat (8) @(posedge wr_clk);
    endtask

    task automatic chk_flags(input string tag, input bit ne, input bit ae,
                             input bit af, input bit nf);
        @(negedge rd_clk);
        chk(rd_nempty == ne, {tag, " rd_nempty"}, 64'(rd_nempty), 64'(ne));
        chk(rd_ae_n == ae, {tag, " R5 rd_ae_n"}, 64'(rd_ae_n), 64'(ae));
        @(negedge wr_clk);
        chk(wr_af_n == af, {tag, " R6 wr_af_n"}, 64'(wr_af_n), 64'(af));
        chk(wr_nfull == nf, {tag, " R2 wr_nfull"}, 64'(wr_nfull), 64'(nf));
    endtask

    task automatic do_reset(input bit std_mode);
        mrst_n = 1'b0;
        tmode = std_mode;
        ae_offset = PW'(AE_OFS);
        af_offset = PW'(AF_OFS);
        wr_cs_n = 1'b1; wr_en = 1'b0; wr_data = '0;
        rd_cs_n = 1'b1; rd_en = 1'b0;
        fwft = !std_mode;
        lvl = 0;
        rseq = wseq;
        repeat (4) @(posedge wr_clk);
        repeat (4) @(posedge rd_clk);
        @(negedge wr_clk);
        mrst_n = 1'b1;
        settle();
    endtask

    task automatic wr_burst(input int n);
        for (int i = 0; i < n; i++) begin
            int  mem;
            bit  exp;
            @(negedge wr_clk);
            mem = lvl - ((fwft && lvl > 0) ? 1 : 0);
            exp = (mem < DEPTH);
            chk(wr_nfull == exp, "R2 write flag", 64'(wr_nfull), 64'(exp));
            wr_cs_n = 1'b0;
            wr_en = 1'b1;
            if (exp) begin
                wr_data = pat(wseq);
                wseq++;
                lvl++;
            end else begin
                wr_data = 36'hBAD0BAD0B;
            end
        end
        @(negedge wr_clk);
        wr_cs_n = 1'b1;
        wr_en = 1'b0;
    endtask

    task automatic rd_burst(input int n);
        @(negedge rd_clk);
        for (int i = 0; i < n; i++) begin
            bit            has;
            logic [DW-1:0] prev;
            has = (lvl > 0);
            chk(rd_nempty == has, fwft ? "R4 ready flag" : "R3 empty flag",
                64'(rd_nempty), 64'(has));
            if (fwft && has)
                chk(rd_data == pat(rseq), "R4 R8 fall-through data",
                    64'(rd_data), 64'(pat(rseq)));
            prev = rd_data;
            rd_cs_n = 1'b0;
            rd_en = 1'b1;
            @(negedge rd_clk);
            if (!fwft) begin
                if (has) chk(rd_data == pat(rseq), "R3 R8 strobed data",
                             64'(rd_data), 64'(pat(rseq)));
                else     chk(rd_data == prev, "R3 empty read ignored",
                             64'(rd_data), 64'(prev));
            end
            if (has) begin
                rseq++;
                lvl--;
            end
        end
        rd_cs_n = 1'b1;
        rd_en = 1'b0;
    endtask

    task automatic wr_poke(input logic cs_n, input logic en);
        @(negedge wr_clk);
        wr_cs_n = cs_n; wr_en = en; wr_data = 36'h5A5A5A5A5;
        @(negedge wr_clk);
        wr_cs_n = 1'b1; wr_en = 1'b0;
    endtask

    task automatic rd_poke(input logic cs_n, input logic en);
        logic [DW-1:0] prev;
        @(negedge rd_clk);
        prev = rd_data;
        rd_cs_n = cs_n; rd_en = en;
        @(negedge rd_clk);
        rd_cs_n = 1'b1; rd_en = 1'b0;
        chk(rd_data == prev, "R1 gated read", 64'(rd_data), 64'(prev));
        chk(rd_nempty == 1'b1, "R1 gated read flag", 64'(rd_nempty), 64'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R9: reset state, strobed mode
        do_reset(1'b1);
        chk_flags("R9 reset std", 1'b0, 1'b0, 1'b1, 1'b1);

        // table: R2 R3 R5 R6 R8 under unrelated clocks
        for (int s = 0; s < 10; s++) begin
            if (VEC[s].nw != 0) wr_burst(int'(VEC[s].nw));
            if (VEC[s].nr != 0) rd_burst(int'(VEC[s].nr));
            settle();
            chk_flags($sformatf("R3 step %0d", s), VEC[s].ne, VEC[s].ae,
                      VEC[s].af, VEC[s].nf);
        end

        // R1: gated writes and reads
        wr_burst(2);
        wr_poke(1'b1, 1'b1);
        wr_poke(1'b0, 1'b0);
        settle();
        rd_poke(1'b1, 1'b1);
        rd_poke(1'b0, 1'b0);
        chk_flags("R1 level two", 1'b1, 1'b0, 1'b1, 1'b1);
        rd_burst(3);
        settle();
        chk_flags("R1 drained", 1'b0, 1'b0, 1'b1, 1'b1);

        // R9: reset with content, into fall-through mode
        wr_burst(3);
        settle();
        do_reset(1'b0);
        chk_flags("R9 reset fwft", 1'b0, 1'b0, 1'b1, 1'b1);

        // R7: pins change after capture, must be ignored
        tmode = 1'b1;
        ae_offset = '0;
        af_offset = PW'(DEPTH);
        wr_burst(1);
        settle();
        @(negedge rd_clk);
        chk(rd_nempty == 1'b1, "R4 R7 word falls through", 64'(rd_nempty), 64'd1);
        chk(rd_data == pat(rseq), "R4 R7 data without strobe",
            64'(rd_data), 64'(pat(rseq)));
        chk(rd_ae_n == 1'b0, "R5 R7 offset kept", 64'(rd_ae_n), 64'd0);

        // fill: memory plus output stage
        wr_burst(19);
        settle();
        chk_flags("R6 fwft full", 1'b1, 1'b1, 1'b0, 1'b0);
        rd_burst(18);
        settle();
        chk_flags("R4 fwft drained", 1'b0, 1'b0, 1'b1, 1'b1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule